// File: doc/BRIEF.md
# Command-Stream Register Write Engine

The engine reads 32-bit words from a command FIFO and turns the packets they form into single register writes on a simple address/data bus with a valid/ready handshake. Software starts a stream by pulsing `start` and giving the stream length in words. The engine decodes each packet from its first word, checks it, fetches any further header and payload words, and issues the writes. Every write address is the active base plus an offset carried in the packet.

Four kinds of work are carried out: contiguous bursts, scattered offset/data pairs, lookup-table loads through a data port (three routing variants), and base switches. A base switch only takes effect if its value matches a valid entry of a small table of allowed bases. That table is loaded through a configuration port while the engine is idle. A malformed packet, an unsupported opcode or a forbidden base stops the stream. The engine then raises an error flag and reports the opcode and word position of the packet that caused it. When every word of the stream has been consumed without a fault, it raises done instead.

Top module: `cs_wr_engine`

## Requirements
- R1: The opcode is bits [31:24] of a packet's first word. Any opcode other than 1, 3, 4, 8, 10 or 11 stops the stream with `err` set, `err_opcode` equal to that opcode and `err_word` equal to the 0-based position of that word in the stream. No further words are taken from the FIFO.
- R2: Opcode 3 (burst) takes a count N from bits [15:0] of word 0 and an offset from bits [23:0] of word 1, ignoring bits [31:24] of word 1. The N data words that follow go to base + offset + 4·i. At the start of every stream the base is 0.
- R3: Opcode 4 (pairs) takes a count N from bits [15:0], followed by N pairs of (offset word, data word). Each data word is written to base + offset, where the offset is bits [23:0] of the offset word.
- R4: A count of zero in an opcode 3 or opcode 4 packet is an error, reported at the packet's first word.
- R5: A packet whose header and payload words exceed the words left in the stream is rejected at its first word. No write of that packet is issued.
- R6: Opcode 1 (table load) has a 3-word header. Bits [15:0] of word 0 hold the byte count minus one, word 1 is ignored, and bits [23:0] of word 2 hold the port offset. It writes floor((len+1)/4) data words to base + port + 8. When that number is zero, only the header is consumed.
- R7: Opcode 10 uses the same header and writes floor((len+1)/4) data words to base + port + 12.
- R8: Opcode 11 uses the same header and writes floor((len+1)/8) word pairs. The first word of each pair goes to base + port + 12 and the second to base + port + 8.
- R9: Opcode 8 carries a base in bits [23:0]. If the base equals the value of a valid entry of the allowed-base table, it becomes the active base for later packets. Otherwise the stream stops with an error.
- R10: A table load (opcode 1, 10 or 11) that arrives before any base switch in the same stream is an error.
- R11: After reset, `busy`, `done`, `err`, `cmd_ready` and `wr_valid` are 0. The engine raises `done` once all `word_count` words are consumed without error, and raises it at once when the count is 0. `done` and `err` are never both set, and each stays set until the next `start`.
- R12: The allowed-base table (8 entries, each a valid bit and a 24-bit value) is written through `cfg_we`. A configuration write made while `busy` is high is ignored.
- R13: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values. Writes are issued in packet order, one at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a stream (taken when not busy) |
| word_count | input | 16 | Number of words in the stream |
| cmd_data | input | 32 | Command FIFO word |
| cmd_valid | input | 1 | FIFO word available |
| cmd_ready | output | 1 | Engine takes the FIFO word this cycle |
| cfg_we | input | 1 | Allowed-base table write strobe |
| cfg_slot | input | 3 | Table entry to write |
| cfg_en | input | 1 | Valid bit for the written entry |
| cfg_base | input | 24 | Base value for the written entry |
| wr_addr | output | 32 | Register write address |
| wr_data | output | 32 | Register write data |
| wr_valid | output | 1 | Write request |
| wr_ready | input | 1 | Write accepted |
| busy | output | 1 | Stream in progress |
| done | output | 1 | Stream finished cleanly |
| err | output | 1 | Stream stopped on a fault |
| err_opcode | output | 8 | Opcode of the faulting packet |
| err_word | output | 16 | Stream position of the faulting packet's first word |

## Verification
The bench targets the routing of table loads. A design that swapped the two port offsets, or got the pair order of the 64-bit variant backwards, would write data to the wrong register. Table loads whose byte count is not a multiple of the word size are also covered: a wrong rounding adds or drops a write. Length checks are driven exactly at and one word past the stream end. A late check would show up as partial writes or extra FIFO pops. The bench also exercises zero counts, table loads issued before any base, bases whose table entry is disabled, and table writes attempted mid-stream, each of which a faulty design would let through. Random FIFO gaps and write-side back-pressure expose any address or data that changes before the write is accepted.

// File: rtl/cs_pkg.sv
package cs_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_HDRX,
        ST_PAY,
        ST_WR,
        ST_DONE,
        ST_ERR
    } cs_state_e;

    localparam logic [7:0] OP_LUT      = 8'd1;
    localparam logic [7:0] OP_BURST    = 8'd3;
    localparam logic [7:0] OP_PAIRS    = 8'd4;
    localparam logic [7:0] OP_BASE     = 8'd8;
    localparam logic [7:0] OP_LUT_LO   = 8'd10;
    localparam logic [7:0] OP_LUT_WIDE = 8'd11;

    localparam int unsigned PORT_MAIN = 8;
    localparam int unsigned PORT_LO   = 12;
endpackage

// File: rtl/cs_base_table.sv
module cs_base_table #(
    parameter int N  = 8,
    parameter int BW = 24,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] slot,
    input  logic          en,
    input  logic [BW-1:0] val,
    input  logic [BW-1:0] query,
    output logic          hit
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [N-1:0] vld_q, vld_d;
    logic [BW-1:0] base_q [N];
    logic [BW-1:0] base_d [N];
    logic [N-1:0] match;

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_comb begin
            vld_d[i]  = vld_q[i];
            base_d[i] = base_q[i];
            if (we && slot == IW'(i)) begin
                vld_d[i]  = en;
                base_d[i] = val;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i]  <= 1'b0;
                base_q[i] <= '0;
            end else begin
                vld_q[i]  <= vld_d[i];
                base_q[i] <= base_d[i];
            end
        end

        assign match[i] = vld_q[i] && (base_q[i] == query);
    end

    assign hit = |match;
endmodule

// File: rtl/cs_seq.sv
module cs_seq
    import cs_pkg::*;
#(
    parameter int CW = 16,
    parameter int AW = 32,
    parameter int BW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] word_count,
    input  logic [31:0]   cmd_data,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    output logic [BW-1:0] base_query,
    input  logic          base_hit,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [7:0]    err_opcode,
    output logic [CW-1:0] err_word
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int XW = CW + 3;

    typedef struct packed {
        cs_state_e     st;
        logic [CW-1:0] rem;
        logic [CW-1:0] idx;
        logic [7:0]    op;
        logic [16:0]   cnt;
        logic [1:0]    hleft;
        logic [BW-1:0] offs;
        logic [BW-1:0] poff;
        logic          ph;
        logic [BW-1:0] base;
        logic          bok;
        logic [AW-1:0] waddr;
        logic [31:0]   wdata;
        logic          done;
        logic          err;
        logic [7:0]    eop;
        logic [CW-1:0] eidx;
    } cs_reg_t;

    cs_reg_t q, d;

    logic [7:0]    op_w;
    logic [15:0]   cnt_w;
    logic [16:0]   len_p1;
    logic [16:0]   lut_words;
    logic [XW-1:0] avail;
    logic          bad;

    function automatic logic [AW-1:0] mk_addr(input logic [BW-1:0] b,
                                              input logic [BW-1:0] o,
                                              input int unsigned k);
        return AW'(b) + AW'(o) + AW'(k);
    endfunction

    always_comb begin
        d         = q;
        cmd_ready = 1'b0;
        bad       = 1'b0;
        op_w      = cmd_data[31:24];
        cnt_w     = cmd_data[15:0];
        len_p1    = {1'b0, cmd_data[15:0]} + 17'd1;
        lut_words = (op_w == OP_LUT_WIDE) ? 17'({len_p1[16:3], 1'b0})
                                          : 17'(len_p1[16:2]);
        avail     = XW'(q.rem) - XW'(1);

        case (q.st)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (start) begin
                    d.st   = ST_HDR;
                    d.rem  = word_count;
                    d.idx  = '0;
                    d.base = '0;
                    d.bok  = 1'b0;
                    d.done = 1'b0;
                    d.err  = 1'b0;
                    d.eop  = '0;
                    d.eidx = '0;
                end
            end
            ST_HDR: begin
                if (q.rem == '0) begin
                    d.st   = ST_DONE;
                    d.done = 1'b1;
                end else begin
                    cmd_ready = 1'b1;
                    if (cmd_valid) begin
                        d.rem = q.rem - 1'b1;
                        d.idx = q.idx + 1'b1;
                        d.op  = op_w;
                        d.ph  = 1'b0;
                        case (op_w)
                            OP_BASE: begin
                                if (base_hit) begin
                                    d.base = cmd_data[BW-1:0];
                                    d.bok  = 1'b1;
                                end else bad = 1'b1;
                            end
                            OP_BURST: begin
                                d.cnt   = {1'b0, cnt_w};
                                d.hleft = 2'd1;
                                d.st    = ST_HDRX;
                                if (cnt_w == '0 || XW'(cnt_w) + XW'(1) > avail) bad = 1'b1;
                            end
                            OP_PAIRS: begin
                                d.cnt = {1'b0, cnt_w};
                                d.st  = ST_PAY;
                                if (cnt_w == '0 || XW'({cnt_w, 1'b0}) > avail) bad = 1'b1;
                            end
                            OP_LUT, OP_LUT_LO, OP_LUT_WIDE: begin
                                d.cnt   = lut_words;
                                d.hleft = 2'd2;
                                d.st    = ST_HDRX;
                                if (!q.bok || XW'(lut_words) + XW'(2) > avail) bad = 1'b1;
                            end
                            default: bad = 1'b1;
                        endcase
                        if (bad) begin
                            d.st   = ST_ERR;
                            d.err  = 1'b1;
                            d.eop  = op_w;
                            d.eidx = q.idx;
                        end
                    end
                end
            end
            ST_HDRX: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    d.rem   = q.rem - 1'b1;
                    d.idx   = q.idx + 1'b1;
                    d.hleft = q.hleft - 2'd1;
                    if (q.hleft == 2'd1) begin
                        d.offs = cmd_data[BW-1:0];
                        d.st   = (q.cnt == '0) ? ST_HDR : ST_PAY;
                    end
                end
            end
            ST_PAY: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    d.rem   = q.rem - 1'b1;
                    d.idx   = q.idx + 1'b1;
                    d.wdata = cmd_data;
                    case (q.op)
                        OP_BURST: begin
                            d.waddr = mk_addr(q.base, q.offs, 0);
                            d.offs  = q.offs + BW'(4);
                            d.cnt   = q.cnt - 1'b1;
                            d.st    = ST_WR;
                        end
                        OP_PAIRS: begin
                            if (!q.ph) begin
                                d.poff = cmd_data[BW-1:0];
                                d.ph   = 1'b1;
                            end else begin
                                d.waddr = mk_addr(q.base, q.poff, 0);
                                d.ph    = 1'b0;
                                d.cnt   = q.cnt - 1'b1;
                                d.st    = ST_WR;
                            end
                        end
                        OP_LUT: begin
                            d.waddr = mk_addr(q.base, q.offs, PORT_MAIN);
                            d.cnt   = q.cnt - 1'b1;
                            d.st    = ST_WR;
                        end
                        OP_LUT_LO: begin
                            d.waddr = mk_addr(q.base, q.offs, PORT_LO);
                            d.cnt   = q.cnt - 1'b1;
                            d.st    = ST_WR;
                        end
                        default: begin
                            d.waddr = mk_addr(q.base, q.offs, q.ph ? PORT_MAIN : PORT_LO);
                            d.ph    = ~q.ph;
                            d.cnt   = q.cnt - 1'b1;
                            d.st    = ST_WR;
                        end
                    endcase
                end
            end
            ST_WR: begin
                if (wr_ready) d.st = (q.cnt == '0) ? ST_HDR : ST_PAY;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign base_query = cmd_data[BW-1:0];
    assign wr_valid   = (q.st == ST_WR);
    assign wr_addr    = q.waddr;
    assign wr_data    = q.wdata;
    assign busy       = !(q.st == ST_IDLE || q.st == ST_DONE || q.st == ST_ERR);
    assign done       = q.done;
    assign err        = q.err;
    assign err_opcode = q.eop;
    assign err_word   = q.eidx;

    // R13
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R11
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    // R11
    idle_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_ready);

    // R1
    err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err && !start |=> err && !busy && $stable(err_word) && $stable(err_opcode));

    // R5
    rem_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> q.rem <= $past(q.rem));
endmodule

// File: rtl/cs_wr_engine.sv
module cs_wr_engine #(
    parameter int CW        = 16,
    parameter int AW        = 32,
    parameter int BW        = 24,
    parameter int NUM_BASES = 8,
    parameter int SW        = $clog2(NUM_BASES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] word_count,
    input  logic [31:0]   cmd_data,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cfg_we,
    input  logic [SW-1:0] cfg_slot,
    input  logic          cfg_en,
    input  logic [BW-1:0] cfg_base,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [7:0]    err_opcode,
    output logic [CW-1:0] err_word
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [BW-1:0] base_query;
    logic          base_hit;
    logic          tbl_we;

    assign tbl_we = cfg_we && !busy;

    cs_base_table #(.N(NUM_BASES), .BW(BW), .IW(SW)) u_tbl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .slot  (cfg_slot),
        .en    (cfg_en),
        .val   (cfg_base),
        .query (base_query),
        .hit   (base_hit)
    );

    cs_seq #(.CW(CW), .AW(AW), .BW(BW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_count (word_count),
        .cmd_data   (cmd_data),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .base_query (base_query),
        .base_hit   (base_hit),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_valid   (wr_valid),
        .wr_ready   (wr_ready),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .err_opcode (err_opcode),
        .err_word   (err_word)
    );
endmodule

// File: tb/sim_cs_wr_engine.sv
module sim_cs_wr_engine;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] word_count = '0;
    logic [31:0] cmd_data = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_slot = '0;
    logic        cfg_en = 1'b0;
    logic [23:0] cfg_base = '0;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic        busy, done, err;
    logic [7:0]  err_opcode;
    logic [15:0] err_word;

    always #2 clk = ~clk;

    cs_wr_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
        .cmd_data(cmd_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .busy(busy), .done(done), .err(err), .err_opcode(err_opcode), .err_word(err_word)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] stream[$];
    logic [31:0] ea[$];
    logic [31:0] ed[$];
    string       et[$];
    logic [23:0] mbase;
    logic [23:0] good_base [4] = '{24'h010000, 24'h020000, 24'h0A0000, 24'h123400};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic clear_model();
        stream.delete(); ea.delete(); ed.delete(); et.delete();
        mbase = '0;
    endtask

    function automatic logic [31:0] mk(input logic [23:0] b, input logic [23:0] o, input int k);
        return 32'(b) + 32'(o) + 32'(k);
    endfunction

    task automatic cfg_write(input logic [2:0] s, input logic e, input logic [23:0] b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_slot = s; cfg_en = e; cfg_base = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_base(input logic [23:0] b);
        stream.push_back({8'd8, b});
        mbase = b;
    endtask

    task automatic put_burst(input logic [23:0] off, input int n);
        logic [31:0] dv;
        stream.push_back({8'd3, 8'd0, 16'(n)});
        stream.push_back({8'hA5, off});
        for (int i = 0; i < n; i++) begin
            dv = $urandom;
            stream.push_back(dv);
            ea.push_back(mk(mbase, off, 4 * i)); ed.push_back(dv); et.push_back("R2");
        end
    endtask

    task automatic put_pairs(input int n);
        logic [31:0] ov, dv;
        stream.push_back({8'd4, 8'd0, 16'(n)});
        for (int i = 0; i < n; i++) begin
            ov = $urandom; dv = $urandom;
            stream.push_back(ov); stream.push_back(dv);
            ea.push_back(mk(mbase, ov[23:0], 0)); ed.push_back(dv); et.push_back("R3");
        end
    endtask

    task automatic put_lut(input logic [7:0] op, input logic [23:0] port, input int len);
        int nw, k;
        logic [31:0] dv;
        nw = (op == 8'd11) ? 2 * ((len + 1) / 8) : (len + 1) / 4;
        stream.push_back({op, 8'd0, 16'(len)});
        stream.push_back($urandom);
        stream.push_back({8'h3C, port});
        for (int i = 0; i < nw; i++) begin
            dv = $urandom;
            stream.push_back(dv);
            k = (op == 8'd1) ? 8 : (op == 8'd10) ? 12 : ((i % 2 == 0) ? 12 : 8);
            ea.push_back(mk(mbase, port, k)); ed.push_back(dv);
            et.push_back((op == 8'd1) ? "R6" : (op == 8'd10) ? "R7" : "R8");
        end
    endtask

    task automatic run(input int words, input bit x_err, input logic [7:0] x_op,
                       input int x_idx, input string tag, input bit cfg_busy);
        int ptr = 0;
        int wn = 0;
        int cyc = 0;
        bit hold = 0;
        logic [31:0] ha = '0, hd = '0;
        @(negedge clk);
        word_count = 16'(words); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (cfg_busy) begin
            chk(busy == 1'b1, "R12 busy during cfg", 32'(busy), 32'd1);
            cfg_we = 1'b1; cfg_slot = 3'd5; cfg_en = 1'b1; cfg_base = 24'h777000;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        while (!(done || err) && cyc < 20000) begin
            cmd_valid = (ptr < stream.size()) && ($urandom % 4 != 0);
            cmd_data  = (ptr < stream.size()) ? stream[ptr] : 32'h0;
            wr_ready  = ($urandom % 3 != 0);
            #1;
            if (hold) chk(wr_valid && wr_addr == ha && wr_data == hd, "R13 hold", wr_addr, ha);
            hold = wr_valid && !wr_ready;
            ha = wr_addr; hd = wr_data;
            if (cmd_valid && cmd_ready) ptr++;
            if (wr_valid && wr_ready) begin
                if (wn < ea.size()) begin
                    chk(wr_addr == ea[wn], {et[wn], " addr"}, wr_addr, ea[wn]);
                    chk(wr_data == ed[wn], {et[wn], " data"}, wr_data, ed[wn]);
                end else begin
                    chk(1'b0, {tag, " extra write"}, wr_addr, 32'h0);
                end
                wn++;
            end
            @(negedge clk);
            cyc++;
        end
        cmd_valid = 1'b0; wr_ready = 1'b0;
        chk(cyc < 20000, {tag, " stream hung"}, 32'(cyc), 32'd20000);
        chk(wn == ea.size(), {tag, " write count"}, 32'(wn), 32'(ea.size()));
        chk(err == x_err && done == !x_err, {tag, " outcome"}, {30'd0, done, err}, {30'd0, !x_err, x_err});
        if (x_err) begin
            chk(err_opcode == x_op, {tag, " err opcode"}, 32'(err_opcode), 32'(x_op));
            chk(err_word == 16'(x_idx), {tag, " err word"}, 32'(err_word), 32'(x_idx));
            chk(ptr == x_idx + 1, {tag, " words taken"}, 32'(ptr), 32'(x_idx + 1));
        end else begin
            chk(ptr == words, {tag, " words taken"}, 32'(ptr), 32'(words));
        end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == !x_err && err == x_err, "R11 flags held",
            {29'd0, busy, done, err}, {30'd0, !x_err, x_err});
        clear_model();
    endtask

    initial begin
        #(4 * 190000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({busy, done, err, cmd_ready, wr_valid} == 5'b0, "R11 reset",
            {27'd0, busy, done, err, cmd_ready, wr_valid}, 32'd0);

        for (int i = 0; i < 4; i++) cfg_write(3'(i), 1'b1, good_base[i]);
        cfg_write(3'd4, 1'b0, 24'h555000);

        // main mix: R2 R3 R6 R7 R8 R9 R11
        put_burst(24'h000040, 2);
        put_base(good_base[0]);
        put_burst(24'h000100, 3);
        put_pairs(2);
        put_lut(8'd1, 24'h000400, 15);
        put_lut(8'd1, 24'h000400, 5);
        put_lut(8'd1, 24'h000400, 2);
        put_base(good_base[3]);
        put_lut(8'd10, 24'h000800, 7);
        put_lut(8'd11, 24'h000C00, 15);
        put_lut(8'd11, 24'h000C00, 8);
        run(stream.size(), 0, 8'd0, 0, "R9 mixed stream", 0);

        // R11 empty stream
        run(0, 0, 8'd0, 0, "R11 zero words", 0);

        // R1 unsupported opcode
        put_base(good_base[1]);
        stream.push_back({8'h05, 24'h0});
        stream.push_back(32'h0300_0001);
        run(stream.size(), 1, 8'h05, 1, "R1 unsupported", 0);

        // R4 zero counts
        stream.push_back({8'd3, 24'h0}); stream.push_back(32'h0);
        run(stream.size(), 1, 8'd3, 0, "R4 burst zero", 0);
        stream.push_back({8'd4, 24'h0});
        run(stream.size(), 1, 8'd4, 0, "R4 pairs zero", 0);

        // R5 payload past stream end
        put_base(good_base[2]);
        stream.push_back({8'd3, 8'd0, 16'd5}); stream.push_back(32'h10);
        for (int i = 0; i < 3; i++) stream.push_back($urandom);
        run(stream.size(), 1, 8'd3, 1, "R5 burst short", 0);
        stream.push_back({8'd4, 8'd0, 16'd3});
        for (int i = 0; i < 5; i++) stream.push_back($urandom);
        run(stream.size(), 1, 8'd4, 0, "R5 pairs short", 0);
        put_base(good_base[0]);
        put_lut(8'd10, 24'h20, 7);
        ea.delete(); ed.delete(); et.delete();
        run(stream.size() - 1, 1, 8'd10, 1, "R5 lut short", 0);

        // R10 table load before base
        put_lut(8'd10, 24'h20, 7);
        ea.delete(); ed.delete(); et.delete();
        run(stream.size(), 1, 8'd10, 0, "R10 no base", 0);

        // R9 disabled entry and unknown base
        stream.push_back({8'd8, 24'h555000});
        run(stream.size(), 1, 8'd8, 0, "R9 disabled entry", 0);
        put_base(good_base[1]);
        stream.push_back({8'd8, 24'hABCDEF});
        run(stream.size(), 1, 8'd8, 1, "R9 unknown base", 0);

        // R12 config write while busy is ignored, then applied when idle
        stream.push_back({8'd8, 24'h777000});
        run(stream.size(), 1, 8'd8, 0, "R12 busy cfg", 1);
        cfg_write(3'd5, 1'b1, 24'h777000);
        put_base(24'h777000);
        put_burst(24'h4, 1);
        run(stream.size(), 0, 8'd0, 0, "R12 idle cfg", 0);

        // random streams
        for (int it = 0; it < 25; it++) begin
            put_base(good_base[$urandom % 4]);
            for (int p = 0; p < 3 + int'($urandom % 4); p++) begin
                case ($urandom % 6)
                    0: put_burst(24'($urandom & 32'hFFF0), 1 + int'($urandom % 6));
                    1: put_pairs(1 + int'($urandom % 4));
                    2: put_lut(8'd1, 24'($urandom & 32'hFFF0), int'($urandom % 40));
                    3: put_lut(8'd10, 24'($urandom & 32'hFFF0), int'($urandom % 40));
                    4: put_lut(8'd11, 24'($urandom & 32'hFFF0), int'($urandom % 40));
                    default: put_base(good_base[$urandom % 4]);
                endcase
            end
            run(stream.size(), 0, 8'd0, 0, "R2 random stream", 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule